// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a load or store and the value to be written back into the base register. It takes the base register value, an offset, and four control bits. The offset is either an unsigned immediate or an index register, and the index register may first be shifted or rotated. The offset is added to or subtracted from the base. Three forms are supported: offset, pre-indexed and post-indexed.

The address arithmetic is combinational. A parameter adds one register stage on the outputs. An index register number equal to the program counter's number is rejected. The block raises an illegal-index flag and suppresses writeback in that case.

Top module: `ea_gen`

## Requirements
- R1: With ctlImm = 1 the offset is the zero-extended immediate. With ctlImm = 0 the offset is indexVal after the selected shift.
- R2: With ctlImm = 1 and immNarrow = 1, only immVal[7:0] forms the offset and immVal[11:8] have no effect. With immNarrow = 0, all 12 bits are used.
- R3: ctlUp = 1 gives base + offset; ctlUp = 0 gives base - offset. wbValue always carries this result.
- R4: Post-index (ctlPre = 0): effAddr equals baseVal, wbValue is base ± offset, and wbEn = 1.
- R5: Offset mode (ctlPre = 1, ctlWb = 0): effAddr is base ± offset and wbEn = 0.
- R6: Pre-index (ctlPre = 1, ctlWb = 1): effAddr is base ± offset, wbValue equals effAddr, and wbEn = 1.
- R7: The shiftType encoding is 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. The shift or rotate is by shiftAmt positions (0 to 31); an amount of 0 leaves the index unchanged.
- R8: With ctlImm = 0 and indexSel = 15, badIndex = 1 and wbEn = 0. With ctlImm = 1, badIndex = 0 whatever the value of indexSel.
- R9: Addition and subtraction wrap modulo 2^32.
- R10: With OUT_REG = 1 (the default), outputs appear one clock after their inputs. While rst_n is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlPre | input | 1 | 1: address includes the offset; 0: post-index |
| ctlUp | input | 1 | 1: add the offset; 0: subtract it |
| ctlWb | input | 1 | With ctlPre = 1, requests writeback |
| ctlImm | input | 1 | 1: immediate offset; 0: index register offset |
| immNarrow | input | 1 | 1: use the 8-bit immediate |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| indexSel | input | 4 | Index register number |
| immVal | input | 12 | Immediate offset |
| shiftType | input | 2 | Index shift kind |
| shiftAmt | input | 5 | Index shift amount |
| effAddr | output | 32 | Memory address |
| wbValue | output | 32 | Value for the base register |
| wbEn | output | 1 | Base writeback enable |
| badIndex | output | 1 | Illegal index register flag |

## Verification
The clocked properties compare each registered output with the inputs of the previous cycle. They therefore assume the default single output stage, and they assume that the inputs are driven to known values from the start of reset. The bench holds every input at a defined value from time zero. It changes the inputs only on the falling clock edge, so each rising edge captures exactly one stimulus set.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_e;

  typedef struct packed {
    logic selImm;
    logic narrowImm;
    logic subtract;
    logic addrFromSum;
    logic wbEn;
    logic badIndex;
  } eaStrobe_t;
endpackage

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
#(
  parameter int REG_ID_W = 4
) (
  input  logic                ctlPre,
  input  logic                ctlUp,
  input  logic                ctlWb,
  input  logic                ctlImm,
  input  logic                immNarrow,
  input  logic [REG_ID_W-1:0] indexSel,
  output eaStrobe_t           strobe
);
  localparam logic [REG_ID_W-1:0] PC_ID = '1;

  logic illegal;

  always_comb begin
    illegal            = !ctlImm && (indexSel == PC_ID);
    strobe.selImm      = ctlImm;
    strobe.narrowImm   = immNarrow;
    strobe.subtract    = !ctlUp;
    strobe.addrFromSum = ctlPre;
    strobe.wbEn        = (!ctlPre || ctlWb) && !illegal;
    strobe.badIndex    = illegal;
  end

  // R8: an illegal index never leaves writeback enabled
  always_comb begin
    if (strobe.badIndex) assert (!strobe.wbEn);
  end
endmodule

// File: rtl/ea_gen_dp.sv
module ea_gen_dp
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 12,
  parameter int NARROW_W = 8,
  parameter int SHAMT_W  = $clog2(ADDR_W)
) (
  input  eaStrobe_t          strobe,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [IMM_W-1:0]   immVal,
  input  logic [1:0]         shiftType,
  input  logic [SHAMT_W-1:0] shiftAmt,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  wbValue
);
  logic [ADDR_W-1:0]   immWide;
  logic [ADDR_W-1:0]   immShort;
  logic [ADDR_W-1:0]   shifted;
  logic [2*ADDR_W-1:0] rotWide;
  logic [ADDR_W-1:0]   offset;
  logic [ADDR_W-1:0]   sum;

  assign immWide  = {{(ADDR_W-IMM_W){1'b0}}, immVal};
  assign immShort = {{(ADDR_W-NARROW_W){1'b0}}, immVal[NARROW_W-1:0]};
  assign rotWide  = {indexVal, indexVal} >> shiftAmt;

  always_comb begin
    unique case (shiftKind_e'(shiftType))
      SH_LSL:  shifted = indexVal << shiftAmt;
      SH_LSR:  shifted = indexVal >> shiftAmt;
      SH_ASR:  shifted = ADDR_W'($signed(indexVal) >>> shiftAmt);
      SH_ROR:  shifted = rotWide[ADDR_W-1:0];
      default: shifted = indexVal;
    endcase
  end

  always_comb begin
    if (strobe.selImm) offset = strobe.narrowImm ? immShort : immWide;
    else               offset = shifted;
    sum     = strobe.subtract ? baseVal - offset : baseVal + offset;
    wbValue = sum;
    effAddr = strobe.addrFromSum ? sum : baseVal;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 12,
  parameter int NARROW_W = 8,
  parameter int REG_ID_W = 4,
  parameter bit OUT_REG  = 1'b1,
  localparam int SHAMT_W = $clog2(ADDR_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctlPre,
  input  logic                ctlUp,
  input  logic                ctlWb,
  input  logic                ctlImm,
  input  logic                immNarrow,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic [ADDR_W-1:0]   indexVal,
  input  logic [REG_ID_W-1:0] indexSel,
  input  logic [IMM_W-1:0]    immVal,
  input  logic [1:0]          shiftType,
  input  logic [SHAMT_W-1:0]  shiftAmt,
  output logic [ADDR_W-1:0]   effAddr,
  output logic [ADDR_W-1:0]   wbValue,
  output logic                wbEn,
  output logic                badIndex
);
  localparam logic [REG_ID_W-1:0] PC_ID = '1;

  eaStrobe_t         strobe;
  logic [ADDR_W-1:0] addrComb;
  logic [ADDR_W-1:0] wbComb;

  ea_gen_ctrl #(.REG_ID_W(REG_ID_W)) u_ctrl (
    .ctlPre(ctlPre), .ctlUp(ctlUp), .ctlWb(ctlWb), .ctlImm(ctlImm),
    .immNarrow(immNarrow), .indexSel(indexSel), .strobe(strobe)
  );

  ea_gen_dp #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .NARROW_W(NARROW_W)) u_dp (
    .strobe(strobe), .baseVal(baseVal), .indexVal(indexVal), .immVal(immVal),
    .shiftType(shiftType), .shiftAmt(shiftAmt),
    .effAddr(addrComb), .wbValue(wbComb)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          effAddr  <= '0;
          wbValue  <= '0;
          wbEn     <= 1'b0;
          badIndex <= 1'b0;
        end else begin
          effAddr  <= addrComb;
          wbValue  <= wbComb;
          wbEn     <= strobe.wbEn;
          badIndex <= strobe.badIndex;
        end
      end

      p_post_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctlPre) |-> effAddr == $past(baseVal));
      p_post_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctlPre && (ctlImm || indexSel != PC_ID)) |-> wbEn);
      p_offset_nowb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctlPre && !ctlWb) |-> !wbEn);
      p_pre_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctlPre && ctlWb && (ctlImm || indexSel != PC_ID)) |-> (wbEn && wbValue == effAddr));
      p_bad_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctlImm && indexSel == PC_ID) |-> (badIndex && !wbEn));
      p_imm_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctlImm) |-> !badIndex);
    end else begin : g_comb
      always_comb begin
        effAddr  = addrComb;
        wbValue  = wbComb;
        wbEn     = strobe.wbEn;
        badIndex = strobe.badIndex;
      end
    end
  endgenerate
endmodule

// File: tb/test_ea_gen.sv
`timescale 1ns/1ps
module test_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctlPre = 1'b0, ctlUp = 1'b0, ctlWb = 1'b0, ctlImm = 1'b0, immNarrow = 1'b0;
  logic [31:0] baseVal = '0, indexVal = '0;
  logic [3:0]  indexSel = '0;
  logic [11:0] immVal = '0;
  logic [1:0]  shiftType = '0;
  logic [4:0]  shiftAmt = '0;
  logic [31:0] effAddr, wbValue;
  logic        wbEn, badIndex;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .ctlPre(ctlPre), .ctlUp(ctlUp), .ctlWb(ctlWb),
    .ctlImm(ctlImm), .immNarrow(immNarrow), .baseVal(baseVal), .indexVal(indexVal),
    .indexSel(indexSel), .immVal(immVal), .shiftType(shiftType), .shiftAmt(shiftAmt),
    .effAddr(effAddr), .wbValue(wbValue), .wbEn(wbEn), .badIndex(badIndex)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one access at the falling edge, let one rising edge capture it,
  // then compare at the following falling edge.
  task automatic apply(input string req, input bit p, input bit u, input bit w, input bit i,
                       input bit nar, input logic [31:0] b, input logic [31:0] x,
                       input logic [3:0] sel, input logic [11:0] imm, input logic [1:0] st,
                       input logic [4:0] sa, input logic [31:0] expOff);
    logic [31:0] sum;
    bit bad;
    ctlPre = p; ctlUp = u; ctlWb = w; ctlImm = i; immNarrow = nar;
    baseVal = b; indexVal = x; indexSel = sel; immVal = imm; shiftType = st; shiftAmt = sa;
    @(posedge clk);
    @(negedge clk);
    sum = u ? b + expOff : b - expOff;
    bad = !i && (sel == 4'hF);
    check({req, " addr"}, effAddr, p ? sum : b);
    check({req, " wbval"}, wbValue, sum);
    check({req, " wben"}, {31'b0, wbEn}, {31'b0, (!p || w) && !bad});
    check({req, " bad"}, {31'b0, badIndex}, {31'b0, bad});
  endtask

  task automatic t_reset;  // R10
    ctlPre = 1'b1; ctlUp = 1'b1; ctlImm = 1'b1; baseVal = 32'h1234; immVal = 12'h10;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset addr", effAddr, 32'h0);
    check("R10 reset wbval", wbValue, 32'h0);
    check("R10 reset wben", {31'b0, wbEn}, 32'h0);
    check("R10 reset bad", {31'b0, badIndex}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_latency;  // R10: output tracks input of previous cycle
    apply("R10 first", 1, 1, 0, 1, 0, 32'h100, 0, 0, 12'h004, 0, 0, 32'h4);
    baseVal = 32'h200;
    #1;
    check("R10 holds before edge", effAddr, 32'h104);
    @(posedge clk); @(negedge clk);
    check("R10 after edge", effAddr, 32'h204);
  endtask

  task automatic t_immediate;  // R1 R2
    apply("R1 wide imm", 1, 1, 0, 1, 0, 32'h1000, 32'hDEAD, 4'h3, 12'hABC, 0, 0, 32'hABC);
    apply("R2 narrow imm", 1, 1, 0, 1, 1, 32'h1000, 0, 0, 12'hFBC, 0, 0, 32'hBC);
    apply("R2 full imm", 1, 1, 0, 1, 0, 32'h1000, 0, 0, 12'hFBC, 0, 0, 32'hFBC);
  endtask

  task automatic t_direction;  // R3
    apply("R3 add", 1, 1, 0, 0, 0, 32'h5000, 32'h30, 4'h2, 0, 0, 0, 32'h30);
    apply("R3 sub", 1, 0, 0, 0, 0, 32'h5000, 32'h30, 4'h2, 0, 0, 0, 32'h30);
  endtask

  task automatic t_forms;  // R4 R5 R6
    apply("R4 post add", 0, 1, 0, 1, 0, 32'h8000, 0, 0, 12'h008, 0, 0, 32'h8);
    apply("R4 post sub w", 0, 0, 1, 1, 0, 32'h8000, 0, 0, 12'h008, 0, 0, 32'h8);
    apply("R5 offset", 1, 1, 0, 1, 0, 32'h8000, 0, 0, 12'h020, 0, 0, 32'h20);
    apply("R6 pre", 1, 0, 1, 0, 0, 32'h8000, 32'h44, 4'h7, 0, 0, 0, 32'h44);
    check("R6 wb equals addr", wbValue, effAddr);
  endtask

  task automatic t_shifts;  // R7
    apply("R7 lsl", 1, 1, 0, 0, 0, 32'h0, 32'h5, 4'h1, 0, 2'b00, 5'd3, 32'h28);
    apply("R7 lsr", 1, 1, 0, 0, 0, 32'h0, 32'h80000010, 4'h1, 0, 2'b01, 5'd4, 32'h08000001);
    apply("R7 asr", 1, 1, 0, 0, 0, 32'h0, 32'h80000010, 4'h1, 0, 2'b10, 5'd4, 32'hF8000001);
    apply("R7 ror", 1, 1, 0, 0, 0, 32'h0, 32'h0000001F, 4'h1, 0, 2'b11, 5'd4, 32'hF0000001);
    apply("R7 ror zero", 1, 1, 0, 0, 0, 32'h0, 32'h12345678, 4'h1, 0, 2'b11, 5'd0, 32'h12345678);
    apply("R7 lsl max", 1, 1, 0, 0, 0, 32'h0, 32'h3, 4'h1, 0, 2'b00, 5'd31, 32'h80000000);
  endtask

  task automatic t_bad_index;  // R8
    apply("R8 pc index pre", 1, 1, 1, 0, 0, 32'h400, 32'h10, 4'hF, 0, 0, 0, 32'h10);
    apply("R8 pc index post", 0, 1, 0, 0, 0, 32'h400, 32'h10, 4'hF, 0, 0, 0, 32'h10);
    apply("R8 imm ignores sel", 1, 1, 1, 1, 0, 32'h400, 32'h10, 4'hF, 12'h2, 0, 0, 32'h2);
    apply("R8 index 14 ok", 1, 1, 1, 0, 0, 32'h400, 32'h10, 4'hE, 0, 0, 0, 32'h10);
  endtask

  task automatic t_wrap;  // R9
    apply("R9 wrap add", 1, 1, 1, 1, 0, 32'hFFFFFFF0, 0, 0, 12'h020, 0, 0, 32'h20);
    check("R9 wrap value", effAddr, 32'h00000010);
    apply("R9 wrap sub", 1, 0, 0, 1, 0, 32'h00000004, 0, 0, 12'h008, 0, 0, 32'h8);
    check("R9 wrap sub value", effAddr, 32'hFFFFFFFC);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_immediate();
    t_direction();
    t_forms();
    t_shifts();
    t_bad_index();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule